// File: doc/BRIEF.md
# SMBus Block Write-Block Read Process Call Controller

This block runs a two-part SMBus exchange as bus master. The first part sends the target address with the write bit, a command code, a write length M and M payload bytes. Then, with no stop in between, it issues a repeated start and the target address with the read bit. The target replies with a read length N followed by N bytes. An optional packet error code (PEC) byte may follow. The block drives a byte-level bit engine through a command stream and a response stream. Software sets it up through a small register window.

A 32-entry byte buffer is shared by both directions. Software fills it with the outgoing payload, and the sequencer overwrites it from entry 0 with the incoming payload. Reading the command-code register rewinds the software pointer. A CRC-8 runs over every byte of the exchange, both address bytes included, and is compared against the trailing PEC byte when PEC is on.

Back-pressure rules:
- **Command stream.** `cmd_valid` stays high, with `cmd_op` and `cmd_byte` unchanged, until a cycle in which `cmd_ready` is high. That cycle transfers the command.
- **Response stream.** The engine returns exactly one response per accepted command. It holds `rsp_valid` until `rsp_ready`, which is high only while a response is awaited.

Top module: `smbus_bwbr_ctrl`

## Requirements
- R1: After reset the status register (offset 0) reads 0 and `cmd_valid` is low.
- R2: A valid request issues the commands in this order, with op codes START=0, RSTART=1, WRITE=2, RD_ACK=3, RD_NAK=4, STOP=5:
  - START;
  - WRITE {target,0};
  - WRITE code;
  - WRITE M;
  - M WRITEs of buffer entries 0..M-1;
  - RSTART;
  - WRITE {target,1};
  - RD_ACK for the count byte;
  - the N data reads;
  - STOP.
- R3: Writing 1 to control bit 0 is rejected when aux bit 0 (offset 7) is clear, M is 0, or M exceeds 31. A rejected request issues no command and sets status bit 5.
- R4: If the received N is 0 or M+N exceeds 32, the next command is one RD_NAK read, then STOP. Status bits 2 (protocol error) and 1 (done) are then set.
- R5: With PEC off (control bit 1 clear) the last data read is RD_NAK. With PEC on, all N data reads are RD_ACK and one further RD_NAK read fetches the PEC byte.
- R6: The PEC is CRC-8 with polynomial x^8+x^2+x+1 and initial value 0. It covers both address bytes, the code, M, the write data, N and the read data. A mismatching PEC byte sets status bit 3; a matching one leaves it clear.
- R7: Received data lands in buffer entries 0..N-1. A read of offset 2 rewinds the software pointer to 0. Each read or write of offset 6 accesses the entry at the pointer and then advances it, wrapping from 31 to 0.
- R8: While `cmd_valid` is high and `cmd_ready` low, the command is held unchanged.
- R9: A write byte answered with NAK is followed directly by STOP and sets status bit 4.
- R10: Status bits 1 to 5 are cleared by writing 1 to them at offset 0. Bit 0 reads busy.
- R11: Offset 5 reads the N received in the last exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effects at offsets 2 and 6) |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data for `host_addr` |
| cmd_valid | output | 1 | Command to bit engine is valid |
| cmd_ready | input | 1 | Bit engine accepts the command |
| cmd_op | output | 3 | Bus operation code |
| cmd_byte | output | 8 | Byte to transmit for WRITE |
| rsp_valid | input | 1 | Bit engine response valid |
| rsp_ready | output | 1 | Controller awaits a response |
| rsp_data | input | 8 | Byte received for a read |
| rsp_nak | input | 1 | Target NAKed a written byte |

## Verification
The bench builds the block with the default 32-entry buffer. This makes both ends of the joint length limit reachable: M=31 with N=1, M=1 with N=31, and the first overflow at M+N=33. It also lets a 33-access sweep cross the pointer wrap from 31 to 0. Randomly chosen M, N, PEC settings and engine stall lengths are mixed with directed cases: a zero count, rejected requests, a NAK on each kind of written byte, and a corrupted PEC byte.

// File: rtl/smbpc_pkg.sv
package smbpc_pkg;
  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_WRITE  = 3'd2,
    OP_RD_ACK = 3'd3,
    OP_RD_NAK = 3'd4,
    OP_STOP   = 3'd5
  } bus_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR_W, S_CODE, S_WCOUNT, S_WDATA, S_RESTART,
    S_ADDR_R, S_RCOUNT, S_RDATA, S_RPEC, S_DRAIN, S_STOP
  } seq_state_e;

  localparam logic [2:0] REG_STATUS = 3'd0;
  localparam logic [2:0] REG_CTRL   = 3'd1;
  localparam logic [2:0] REG_CODE   = 3'd2;
  localparam logic [2:0] REG_TARGET = 3'd3;
  localparam logic [2:0] REG_WCOUNT = 3'd4;
  localparam logic [2:0] REG_RCOUNT = 3'd5;
  localparam logic [2:0] REG_DATA   = 3'd6;
  localparam logic [2:0] REG_AUX    = 3'd7;

  // One byte through CRC-8, polynomial 0x07, MSB first
  function automatic logic [7:0] crc8_next(input logic [7:0] crc, input logic [7:0] din);
    logic [7:0] c;
    c = crc ^ din;
    for (int i = 0; i < 8; i++)
      c = c[7] ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
    return c;
  endfunction
endpackage

// File: rtl/smbpc_crc8.sv
module smbpc_crc8
  import smbpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= 8'h00;
    else if (clr) crc <= 8'h00;
    else if (en)  crc <= crc8_next(crc, din);
  end

  // R6: accumulator starts from zero for each exchange
  assert_crc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> crc == 8'h00);
  // R6: only counted bytes move the accumulator
  assert_crc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(crc));
endmodule

// File: rtl/smbpc_buf.sv
module smbpc_buf #(
  parameter  int DEPTH = 32,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_clr,
  input  logic          host_step,
  input  logic          host_we,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          eng_we,
  input  logic [PW-1:0] eng_idx,
  input  logic [7:0]    eng_wdata,
  output logic [7:0]    eng_rdata
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr <= '0;
    else if (host_clr)  ptr <= '0;
    else if (host_step) ptr <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (eng_we)       mem[eng_idx] <= eng_wdata;
    else if (host_we) mem[ptr]     <= host_wdata;
  end

  assign host_rdata = mem[ptr];
  assign eng_rdata  = mem[eng_idx];

  // R7: rewind lands on entry 0
  assert_ptr_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_clr |=> ptr == '0);
  // R7: each data access moves one entry on, wrapping at the end
  assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_step && !host_clr) |=>
      ptr == (($past(ptr) == PW'(DEPTH - 1)) ? '0 : $past(ptr) + PW'(1)));
endmodule

// File: rtl/smbpc_seq.sv
module smbpc_seq
  import smbpc_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          pec_en,
  input  logic          en_big,
  input  logic [6:0]    tgt_addr,
  input  logic [7:0]    code,
  input  logic [7:0]    wcnt,
  output logic [PW-1:0] buf_idx,
  output logic          buf_we,
  output logic [7:0]    buf_wdata,
  input  logic [7:0]    buf_rdata,
  output logic          crc_clr,
  output logic          crc_en,
  output logic [7:0]    crc_din,
  input  logic [7:0]    crc_val,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [2:0]    cmd_op,
  output logic [7:0]    cmd_byte,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [7:0]    rsp_data,
  input  logic          rsp_nak,
  output logic          busy,
  output logic [7:0]    rcnt,
  output logic          ev_done,
  output logic          ev_proto,
  output logic          ev_pec,
  output logic          ev_dev,
  output logic          ev_rej
);
  seq_state_e    st;
  logic          wait_q;
  logic [PW-1:0] idx;
  bus_op_e       op;

  logic rsp_fire, is_wr, go_ok, bad_n, last_rd, last_wr;
  assign rsp_fire = rsp_valid && rsp_ready;
  assign is_wr    = (st == S_ADDR_W) || (st == S_CODE) || (st == S_WCOUNT) ||
                    (st == S_WDATA)  || (st == S_ADDR_R);
  assign go_ok    = en_big && (wcnt != 8'd0) && (wcnt <= 8'(DEPTH - 1));
  assign bad_n    = (rsp_data == 8'd0) || (({1'b0, wcnt} + {1'b0, rsp_data}) > 9'(DEPTH));
  assign last_rd  = (8'(idx) + 8'd1) == rcnt;
  assign last_wr  = (8'(idx) + 8'd1) == wcnt;

  always_comb begin
    op       = OP_WRITE;
    cmd_byte = 8'h00;
    unique case (st)
      S_START:   op = OP_START;
      S_ADDR_W:  cmd_byte = {tgt_addr, 1'b0};
      S_CODE:    cmd_byte = code;
      S_WCOUNT:  cmd_byte = wcnt;
      S_WDATA:   cmd_byte = buf_rdata;
      S_RESTART: op = OP_RSTART;
      S_ADDR_R:  cmd_byte = {tgt_addr, 1'b1};
      S_RCOUNT:  op = OP_RD_ACK;
      S_RDATA:   op = (last_rd && !pec_en) ? OP_RD_NAK : OP_RD_ACK;
      S_RPEC, S_DRAIN: op = OP_RD_NAK;
      S_STOP:    op = OP_STOP;
      default:   op = OP_START;
    endcase
  end

  assign cmd_op    = op;
  assign cmd_valid = (st != S_IDLE) && !wait_q;
  assign rsp_ready = wait_q;
  assign busy      = st != S_IDLE;

  assign crc_clr   = (st == S_IDLE) && go && go_ok;
  assign crc_en    = rsp_fire && ((is_wr && !rsp_nak) || st == S_RCOUNT || st == S_RDATA);
  assign crc_din   = is_wr ? cmd_byte : rsp_data;
  assign buf_idx   = idx;
  assign buf_we    = rsp_fire && (st == S_RDATA);
  assign buf_wdata = rsp_data;

  assign ev_rej   = (st == S_IDLE) && go && !go_ok;
  assign ev_done  = rsp_fire && (st == S_STOP);
  assign ev_dev   = rsp_fire && is_wr && rsp_nak;
  assign ev_proto = rsp_fire && (st == S_DRAIN);
  assign ev_pec   = rsp_fire && (st == S_RPEC) && (rsp_data != crc_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      wait_q <= 1'b0;
      idx    <= '0;
      rcnt   <= 8'd0;
    end else begin
      if (cmd_valid && cmd_ready) wait_q <= 1'b1;
      if (st == S_IDLE) begin
        if (go && go_ok) st <= S_START;
      end else if (rsp_fire) begin
        wait_q <= 1'b0;
        if (is_wr && rsp_nak) st <= S_STOP;
        else begin
          unique case (st)
            S_START:   st <= S_ADDR_W;
            S_ADDR_W:  st <= S_CODE;
            S_CODE:    st <= S_WCOUNT;
            S_WCOUNT:  begin st <= S_WDATA; idx <= '0; end
            S_WDATA:   if (last_wr) st <= S_RESTART; else idx <= idx + PW'(1);
            S_RESTART: st <= S_ADDR_R;
            S_ADDR_R:  st <= S_RCOUNT;
            S_RCOUNT: begin
              rcnt <= rsp_data;
              idx  <= '0;
              st   <= bad_n ? S_DRAIN : S_RDATA;
            end
            S_RDATA:   if (last_rd) st <= pec_en ? S_RPEC : S_STOP; else idx <= idx + PW'(1);
            S_RPEC, S_DRAIN: st <= S_STOP;
            S_STOP:    st <= S_IDLE;
            default:   st <= S_IDLE;
          endcase
        end
      end
    end
  end

  // R8: an offered command stays put until taken
  assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte));
  // R3: a rejected request leaves the sequencer idle
  assert_reject_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rej |=> (st == S_IDLE) && !cmd_valid);
  // R4: after the drain read only STOP may follow
  assert_drain_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_proto |=> cmd_valid && (cmd_op == OP_STOP));
  // R9: a NAKed write is followed by STOP
  assert_nak_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dev |=> cmd_valid && (cmd_op == OP_STOP));
endmodule

// File: rtl/smbus_bwbr_ctrl.sv
module smbus_bwbr_ctrl
  import smbpc_pkg::*;
#(
  parameter  int BUF_DEPTH = 32,
  localparam int PW        = $clog2(BUF_DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [2:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [2:0] cmd_op,
  output logic [7:0] cmd_byte,
  input  logic       rsp_valid,
  output logic       rsp_ready,
  input  logic [7:0] rsp_data,
  input  logic       rsp_nak
);
  logic [7:0] code_q, wcnt_q, rcnt;
  logic [6:0] tgt_q;
  logic       pec_en_q, en_big_q, busy;
  logic       st_done, st_proto, st_pec, st_dev, st_rej;
  logic       ev_done, ev_proto, ev_pec, ev_dev, ev_rej;
  logic       go, cfg_wr, st_w1c;

  logic [PW-1:0] eng_idx;
  logic          eng_we, crc_clr, crc_en;
  logic [7:0]    eng_wdata, eng_rdata, buf_hrdata, crc_din, crc_val;

  assign cfg_wr = host_wr && !busy;
  assign go     = host_wr && (host_addr == REG_CTRL) && host_wdata[0];
  assign st_w1c = host_wr && (host_addr == REG_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= 8'd0; wcnt_q <= 8'd0; tgt_q <= 7'd0;
      pec_en_q <= 1'b0; en_big_q <= 1'b0;
    end else if (cfg_wr) begin
      unique case (host_addr)
        REG_CTRL:   pec_en_q <= host_wdata[1];
        REG_CODE:   code_q   <= host_wdata;
        REG_TARGET: tgt_q    <= host_wdata[6:0];
        REG_WCOUNT: wcnt_q   <= host_wdata;
        REG_AUX:    en_big_q <= host_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {st_rej, st_dev, st_pec, st_proto, st_done} <= '0;
    end else begin
      st_done  <= ev_done  | (st_done  & ~(st_w1c & host_wdata[1]));
      st_proto <= ev_proto | (st_proto & ~(st_w1c & host_wdata[2]));
      st_pec   <= ev_pec   | (st_pec   & ~(st_w1c & host_wdata[3]));
      st_dev   <= ev_dev   | (st_dev   & ~(st_w1c & host_wdata[4]));
      st_rej   <= ev_rej   | (st_rej   & ~(st_w1c & host_wdata[5]));
    end
  end

  always_comb begin
    unique case (host_addr)
      REG_STATUS: host_rdata = {2'b00, st_rej, st_dev, st_pec, st_proto, st_done, busy};
      REG_CTRL:   host_rdata = {6'd0, pec_en_q, 1'b0};
      REG_CODE:   host_rdata = code_q;
      REG_TARGET: host_rdata = {1'b0, tgt_q};
      REG_WCOUNT: host_rdata = wcnt_q;
      REG_RCOUNT: host_rdata = rcnt;
      REG_DATA:   host_rdata = buf_hrdata;
      default:    host_rdata = {7'd0, en_big_q};
    endcase
  end

  smbpc_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk, .rst_n,
    .host_clr  (host_rd && (host_addr == REG_CODE)),
    .host_step ((host_rd || host_wr) && (host_addr == REG_DATA)),
    .host_we   (cfg_wr && (host_addr == REG_DATA)),
    .host_wdata(host_wdata),
    .host_rdata(buf_hrdata),
    .eng_we    (eng_we),
    .eng_idx   (eng_idx),
    .eng_wdata (eng_wdata),
    .eng_rdata (eng_rdata)
  );

  smbpc_crc8 u_crc (
    .clk, .rst_n, .clr(crc_clr), .en(crc_en), .din(crc_din), .crc(crc_val)
  );

  smbpc_seq #(.DEPTH(BUF_DEPTH)) u_seq (
    .clk, .rst_n, .go, .pec_en(pec_en_q), .en_big(en_big_q), .tgt_addr(tgt_q),
    .code(code_q), .wcnt(wcnt_q),
    .buf_idx(eng_idx), .buf_we(eng_we), .buf_wdata(eng_wdata), .buf_rdata(eng_rdata),
    .crc_clr, .crc_en, .crc_din, .crc_val,
    .cmd_valid, .cmd_ready, .cmd_op, .cmd_byte,
    .rsp_valid, .rsp_ready, .rsp_data, .rsp_nak,
    .busy, .rcnt, .ev_done, .ev_proto, .ev_pec, .ev_dev, .ev_rej
  );

  // R10: a write of 1 clears the done flag unless a completion coincides
  assert_w1c_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_w1c && host_wdata[1] && !ev_done) |=> !st_done);
  // R3: a rejected request never shows busy
  assert_reject_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rej |=> st_rej && !busy);
endmodule

// File: tb/smbus_bwbr_ctrl_tb_top.sv
module smbus_bwbr_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0;
  logic [2:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic cmd_valid, cmd_ready = 0, rsp_ready;
  logic [2:0] cmd_op;
  logic [7:0] cmd_byte;
  logic rsp_valid = 0, rsp_nak = 0;
  logic [7:0] rsp_data = 0;

  always #2 clk = ~clk;

  smbus_bwbr_ctrl dut_i (
    .clk, .rst_n, .host_wr, .host_rd, .host_addr, .host_wdata, .host_rdata,
    .cmd_valid, .cmd_ready, .cmd_op, .cmd_byte,
    .rsp_valid, .rsp_ready, .rsp_data, .rsp_nak
  );

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  // target model state
  int sl_n, sl_nak_idx, wr_seen, rd_seen;
  logic [7:0] sl_data [32];
  logic [7:0] sl_pec;
  int tr_op [100];
  logic [7:0] tr_b [100];
  int tr_n;
  int ex_op [100];
  logic [7:0] ex_b [100];
  int ex_n;

  function automatic logic [7:0] crc_add(input logic [7:0] c0, input logic [7:0] d);
    logic [7:0] c;
    c = c0 ^ d;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic hwr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1; #1 d = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  // bit engine and target model
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        int op;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        op = int'(cmd_op);
        if (tr_n < 100) begin tr_op[tr_n] = op; tr_b[tr_n] = cmd_byte; end
        tr_n++;
        cmd_ready = 1;
        @(negedge clk); cmd_ready = 0;
        rsp_nak = 0; rsp_data = 8'h00;
        if (op == 2) begin
          rsp_nak = (wr_seen == sl_nak_idx);
          wr_seen++;
        end else if (op == 3 || op == 4) begin
          if (rd_seen == 0) rsp_data = 8'(sl_n);
          else if (rd_seen <= sl_n) rsp_data = sl_data[rd_seen - 1];
          else rsp_data = sl_pec;
          rd_seen++;
        end
        repeat ($urandom_range(0, 2)) @(negedge clk);
        rsp_valid = 1;
        @(negedge clk); rsp_valid = 0;
      end
    end
  end

  task automatic ex_push(input int op, input logic [7:0] b);
    ex_op[ex_n] = op; ex_b[ex_n] = b; ex_n++;
  endtask

  task automatic run_xfer(input int m, input int n, input bit pec, input bit pec_good,
                          input int nak_idx, input bit en, input string req);
    logic [7:0] code, rd, wdat [32];
    logic [6:0] tgt;
    logic [7:0] crc, exp_st;
    bit rej, bad, dev, done_ok;
    int mism, wi;
    code = 8'($urandom); tgt = 7'($urandom);
    for (int i = 0; i < 32; i++) begin wdat[i] = 8'($urandom); sl_data[i] = 8'($urandom); end
    sl_n = n; sl_nak_idx = nak_idx; wr_seen = 0; rd_seen = 0;
    rej = !en || m == 0 || m > 31;
    bad = (n == 0) || (m + n > 32);
    dev = !rej && nak_idx >= 0 && nak_idx <= m + 3;
    // expected PEC over the full message
    crc = 8'h00;
    crc = crc_add(crc, {tgt, 1'b0}); crc = crc_add(crc, code); crc = crc_add(crc, 8'(m));
    for (int i = 0; i < m && i < 32; i++) crc = crc_add(crc, wdat[i]);
    crc = crc_add(crc, {tgt, 1'b1}); crc = crc_add(crc, 8'(n));
    for (int i = 0; i < n && i < 32; i++) crc = crc_add(crc, sl_data[i]);
    sl_pec = pec_good ? crc : (crc ^ 8'h5A);
    // expected command trace
    ex_n = 0;
    if (!rej) begin
      ex_push(0, 0);
      wi = 0;
      begin : build
        logic [7:0] wl [36];
        wl[0] = {tgt, 1'b0}; wl[1] = code; wl[2] = 8'(m);
        for (int i = 0; i < m; i++) wl[3 + i] = wdat[i];
        for (int i = 0; i < m + 3; i++) begin
          ex_push(2, wl[i]);
          if (i == nak_idx) begin ex_push(5, 0); disable build; end
        end
        ex_push(1, 0);
        ex_push(2, {tgt, 1'b1});
        if (nak_idx == m + 3) begin ex_push(5, 0); disable build; end
        ex_push(3, 0);
        if (bad) begin ex_push(4, 0); ex_push(5, 0); disable build; end
        for (int i = 0; i < n; i++) ex_push((i == n - 1 && !pec) ? 4 : 3, 0);
        if (pec) ex_push(4, 0);
        ex_push(5, 0);
      end
    end
    // program the block
    hwr(3'd0, 8'hFF);
    hwr(3'd7, {7'd0, en});
    hwr(3'd3, {1'b0, tgt});
    hwr(3'd2, code);
    hwr(3'd4, 8'(m));
    hrd(3'd2, rd);
    for (int i = 0; i < m && i < 32; i++) hwr(3'd6, wdat[i]);
    tr_n = 0;
    hwr(3'd1, {6'd0, pec, 1'b1});
    for (int k = 0; k < 4000; k++) begin
      hrd(3'd0, rd);
      if (!rd[0]) break;
    end
    // trace comparison (R2, R4, R5, R9 depending on case)
    mism = 0;
    for (int i = 0; i < ex_n && i < tr_n; i++) begin
      if (tr_op[i] != ex_op[i]) mism++;
      else if (ex_op[i] == 2 && tr_b[i] != ex_b[i]) mism++;
    end
    chk(tr_n == ex_n, req, "command count", tr_n, ex_n);
    chk(mism == 0, req, "command mismatches", mism, 0);
    // status register
    done_ok = !rej;
    exp_st = {2'b00, rej, dev, (!rej && !dev && !bad && pec && !pec_good),
              (!rej && !dev && bad), done_ok, 1'b0};
    hrd(3'd0, rd);
    chk(rd == exp_st, rej ? "R3" : (dev ? "R9" : (bad ? "R4" : (pec ? "R6" : req))),
        "status", rd, exp_st);
    if (!rej && !dev) begin
      hrd(3'd5, rd);
      chk(rd == 8'(n), "R11", "read count register", rd, n);
    end
    if (!rej && !dev && !bad) begin
      mism = 0;
      hrd(3'd2, rd);
      for (int i = 0; i < n; i++) begin
        hrd(3'd6, rd);
        if (rd != sl_data[i]) mism++;
      end
      chk(mism == 0, "R7", "received buffer bytes wrong", mism, 0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cmd_valid == 1'b0, "R1", "cmd_valid in reset", cmd_valid, 0);
    rst_n = 1;
    hrd(3'd0, rd);
    chk(rd == 8'h00, "R1", "status after reset", rd, 0);

    // directed corner cases
    run_xfer(6, 4, 0, 1, -1, 1, "R2");
    run_xfer(31, 1, 1, 1, -1, 1, "R5");
    run_xfer(1, 31, 0, 1, -1, 1, "R5");
    run_xfer(3, 5, 1, 0, -1, 1, "R6");
    run_xfer(5, 27, 1, 1, -1, 1, "R6");
    run_xfer(4, 0, 0, 1, -1, 1, "R4");
    run_xfer(5, 28, 1, 1, -1, 1, "R4");
    run_xfer(0, 3, 0, 1, -1, 1, "R3");
    run_xfer(32, 1, 0, 1, -1, 1, "R3");
    run_xfer(4, 2, 0, 1, -1, 0, "R3");
    run_xfer(4, 2, 0, 1, 0, 1, "R9");
    run_xfer(4, 2, 1, 1, 5, 1, "R9");
    run_xfer(4, 2, 1, 1, 7, 1, "R9");

    // R10: write-1-to-clear after a run left flags set
    run_xfer(2, 2, 1, 0, -1, 1, "R6");
    hwr(3'd0, 8'h3E);
    hrd(3'd0, rd);
    chk(rd == 8'h00, "R10", "status after clear", rd, 0);

    // R7: pointer wrap over 33 data-register writes
    hrd(3'd2, rd);
    for (int i = 0; i < 33; i++) hwr(3'd6, 8'(i + 100));
    hrd(3'd2, rd);
    hrd(3'd6, rd);
    chk(rd == 8'd132, "R7", "entry 0 after wrap", rd, 132);
    hrd(3'd6, rd);
    chk(rd == 8'd101, "R7", "entry 1 after rewind", rd, 101);

    // constrained random exchanges
    for (int t = 0; t < 14; t++) begin
      int m, n;
      m = $urandom_range(1, 20);
      n = $urandom_range(1, 32 - m);
      run_xfer(m, n, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0), -1, 1, "R2");
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule